// File: doc/BRIEF.md
# Word-to-Byte UART Streamer

The streamer takes wide words from an upstream producer and sends each one out of a single asynchronous serial transmit line, one byte lane at a time. A one-cycle strobe on `in_valid` captures `in_word` into an internal register. A sequencing state machine then hands the lanes to a frame serializer, starting with the least significant lane. The serializer wraps each byte in a low start bit and a high stop bit and shifts the data out. A bit timer, which runs only while a frame is on the line, sets the length of every bit.

The sequencer has three states. In IDLE it waits for the strobe. On a strobe it captures the word, points at lane 0 and moves to LOAD. LOAD drives a one-cycle load pulse into the serializer and always moves to WAIT. WAIT holds until the serializer is free again. From WAIT it returns to LOAD with the next lane, or to IDLE once the last lane has gone out.

The serializer has four states. IDLE moves to START on a load pulse. START moves to DATA on a bit tick. DATA moves to STOP on the tick that ends the last data bit. STOP moves back to IDLE on its tick. A strobe that arrives while a burst is in progress is discarded and reported by a one-cycle drop pulse.

Top module: `word_uart_streamer`

## Requirements
- R1: After reset and between bursts, `tx_line` is 1, `stream_busy` is 0 and `drop_pulse` is 0.
- R2: Every byte leaves as one frame with the following order: a start bit of 0, then the 8 data bits with bit 0 first, then a stop bit of 1.
- R3: Each start, data and stop bit holds `tx_line` for exactly CLKS_PER_BIT clock cycles. A start bit followed by eight data bits of 0 is therefore low for 9×CLKS_PER_BIT cycles.
- R4: Each accepted word produces exactly four frames. They carry `in_word[7:0]`, `[15:8]`, `[23:16]` and `[31:24]`, in that order.
- R5: The word is captured on the cycle its strobe is accepted. Changes on `in_word` during the burst do not alter any transmitted byte.
- R6: `stream_busy` is 1 from the cycle after an accepted strobe until the last stop bit has ended, and it reads 0 within CLKS_PER_BIT cycles of the middle of that stop bit. A new frame is never loaded while the previous one is still on the line.
- R7: A strobe that arrives while `stream_busy` is 1 produces a `drop_pulse` of exactly one cycle, on the following cycle. The dropped word is never transmitted.
- R8: A strobe that arrives after a burst has finished is accepted, so words may follow one another back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_word | input | WORD_W | Word offered by the producer |
| in_valid | input | 1 | One-cycle strobe marking `in_word` as new |
| tx_line | output | 1 | Serial transmit line, idles high |
| stream_busy | output | 1 | A burst is in progress |
| drop_pulse | output | 1 | One-cycle pulse: a strobe arrived during a burst and was discarded |

## Verification
The bench builds the streamer with CLKS_PER_BIT = 4, 32-bit words and 8-bit lanes. With these values a complete four-frame burst takes under two hundred cycles, so many words can be streamed back to back, and a second strobe can be placed in the middle of a burst. Short bits also let the bench measure the exact length of a start bit, and of a start bit merged with a run of zero data bits, cycle by cycle. It also lets the bench decode every frame at bit centres, two cycles from each edge.

// File: rtl/streamer_pkg.sv
package streamer_pkg;

    typedef enum logic [1:0] {
        SER_IDLE  = 2'd0,
        SER_START = 2'd1,
        SER_DATA  = 2'd2,
        SER_STOP  = 2'd3
    } ser_state_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LOAD = 2'd1,
        SEQ_WAIT = 2'd2
    } seq_state_t;

endpackage

// File: rtl/bit_timer.sv
module bit_timer #(
    parameter int CLKS_PER_BIT = 868
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic bit_tick
);
    localparam int CNT_W = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_BIT - 1);

    logic [CNT_W-1:0] cnt_q;

    // Counter restarts whenever the line is idle, so the first bit is full length.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (!run)          cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + CNT_W'(1);
    end

    assign bit_tick = run && (cnt_q == LAST);

    // R3: ticks are separated by at least one cycle (bit length >= 2)
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);

endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
    import streamer_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data_in,
    input  logic              bit_tick,
    output logic              busy,
    output logic              tx
);
    localparam int IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(DATA_W - 1);

    ser_state_t        state_q, state_d;
    logic [DATA_W-1:0] shift_q;
    logic [IDX_W-1:0]  idx_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SER_IDLE:  if (load)                           state_d = SER_START;
            SER_START: if (bit_tick)                       state_d = SER_DATA;
            SER_DATA:  if (bit_tick && idx_q == LAST_BIT)  state_d = SER_STOP;
            SER_STOP:  if (bit_tick)                       state_d = SER_IDLE;
            default:                                       state_d = SER_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SER_IDLE;
            shift_q <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SER_IDLE && load) begin
                shift_q <= data_in;
                idx_q   <= '0;
            end else if (state_q == SER_DATA && bit_tick) begin
                shift_q <= shift_q >> 1;
                idx_q   <= idx_q + IDX_W'(1);
            end
        end
    end

    always_comb begin
        busy = (state_q != SER_IDLE);
        unique case (state_q)
            SER_IDLE:  tx = 1'b1;
            SER_START: tx = 1'b0;
            SER_DATA:  tx = shift_q[0];
            SER_STOP:  tx = 1'b1;
            default:   tx = 1'b1;
        endcase
    end

    // R6: the sequencer never loads while a frame is on the line
    p_load_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy);
    // R2: a frame opens with the line low
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (tx == 1'b0));
    // R3: the line only moves on a bit boundary during a frame
    p_line_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_tick) |=> $stable(tx));

endmodule

// File: rtl/word_sequencer.sv
module word_sequencer
    import streamer_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_valid,
    input  logic              tx_busy,
    output logic              load,
    output logic [BYTE_W-1:0] byte_out,
    output logic              stream_busy,
    output logic              drop_pulse
);
    localparam int LANES = WORD_W / BYTE_W;
    localparam int IDX_W = (LANES > 2) ? $clog2(LANES) : 1;
    localparam logic [IDX_W-1:0] LAST_LANE = IDX_W'(LANES - 1);

    seq_state_t        st_q, st_d;
    logic [WORD_W-1:0] word_q;
    logic [IDX_W-1:0]  lane_q;
    logic              drop_q;
    logic [BYTE_W-1:0] lane_bytes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bytes[g] = word_q[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SEQ_IDLE: if (in_valid) st_d = SEQ_LOAD;
            SEQ_LOAD: st_d = SEQ_WAIT;
            SEQ_WAIT: if (!tx_busy) st_d = (lane_q == LAST_LANE) ? SEQ_IDLE : SEQ_LOAD;
            default:  st_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= SEQ_IDLE;
            word_q <= '0;
            lane_q <= '0;
            drop_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            drop_q <= in_valid && (st_q != SEQ_IDLE);
            if (st_q == SEQ_IDLE && in_valid) begin
                word_q <= in_word;
                lane_q <= '0;
            end else if (st_q == SEQ_WAIT && !tx_busy && lane_q != LAST_LANE) begin
                lane_q <= lane_q + IDX_W'(1);
            end
        end
    end

    always_comb begin
        load        = (st_q == SEQ_LOAD);
        byte_out    = lane_bytes[lane_q];
        stream_busy = (st_q != SEQ_IDLE);
        drop_pulse  = drop_q;
    end

    // R7: a strobe during a burst is reported on the next cycle
    p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && stream_busy) |=> drop_pulse);
    // R6: an accepted strobe opens a burst without a drop report
    p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !stream_busy) |=> (stream_busy && !drop_pulse));
    // R5: the byte handed over stays fixed while its frame is sent
    p_byte_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SEQ_WAIT) |-> $stable(byte_out));

endmodule

// File: rtl/word_uart_streamer.sv
module word_uart_streamer #(
    parameter int CLKS_PER_BIT = 868,
    parameter int WORD_W       = 32,
    parameter int BYTE_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_valid,
    output logic              tx_line,
    output logic              stream_busy,
    output logic              drop_pulse
);
    logic              ser_busy;
    logic              ser_load;
    logic              bit_tick;
    logic [BYTE_W-1:0] ser_byte;

    word_sequencer #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_word     (in_word),
        .in_valid    (in_valid),
        .tx_busy     (ser_busy),
        .load        (ser_load),
        .byte_out    (ser_byte),
        .stream_busy (stream_busy),
        .drop_pulse  (drop_pulse)
    );

    bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ser_busy),
        .bit_tick (bit_tick)
    );

    frame_serializer #(.DATA_W(BYTE_W)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ser_load),
        .data_in  (ser_byte),
        .bit_tick (bit_tick),
        .busy     (ser_busy),
        .tx       (tx_line)
    );

    // R1: an idle streamer keeps the line at the mark level
    p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!stream_busy && !ser_busy) |-> tx_line);

endmodule

// File: tb/word_uart_streamer_tb.sv
module word_uart_streamer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CPB        = 4;
    localparam int NVEC       = 6;
    localparam logic [31:0] VEC [NVEC] = '{
        32'h0403_0201, 32'hA5C3_3C5A, 32'hFFFF_FFFF,
        32'h0000_0000, 32'h8000_0001, 32'h7E81_18E7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_valid = 1'b0;
    logic        tx_line, stream_busy, drop_pulse;
    int          n_tests = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    word_uart_streamer #(.CLKS_PER_BIT(CPB), .WORD_W(32), .BYTE_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
        .tx_line(tx_line), .stream_busy(stream_busy), .drop_pulse(drop_pulse)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send_word(input logic [31:0] w);
        @(negedge clk);
        in_word  = w;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b, output logic start_ok, output logic stop_ok);
        @(negedge clk);
        while (tx_line !== 1'b0) @(negedge clk);
        repeat (CPB/2) @(negedge clk);
        start_ok = (tx_line == 1'b0);
        for (int k = 0; k < 8; k++) begin
            repeat (CPB) @(negedge clk);
            b[k] = tx_line;
        end
        repeat (CPB) @(negedge clk);
        stop_ok = (tx_line == 1'b1);
    endtask

    task automatic recv_word(input logic [31:0] exp, input string req);
        logic [7:0] b;
        logic       s0, s1;
        for (int n = 0; n < 4; n++) begin
            recv_byte(b, s0, s1);
            check(b == exp[8*n +: 8], req, "byte lane", {24'd0, b}, {24'd0, exp[8*n +: 8]});
            check(s0 && s1, "R2", "frame start/stop", {30'd0, s0, s1}, 32'd3);
        end
    endtask

    task automatic low_run(output int len);
        len = 0;
        @(negedge clk);
        while (tx_line !== 1'b0) @(negedge clk);
        while (tx_line == 1'b0) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle;
        while (stream_busy) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int len;
        logic ok_all;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(tx_line == 1'b1, "R1", "tx after reset", {31'd0, tx_line}, 32'd1);
        check(!stream_busy && !drop_pulse, "R1", "flags after reset",
              {30'd0, stream_busy, drop_pulse}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(tx_line == 1'b1, "R1", "tx idle out of reset", {31'd0, tx_line}, 32'd1);

        // R4 / R8: vector table, words back to back
        for (int i = 0; i < NVEC; i++) begin
            send_word(VEC[i]);
            check(stream_busy == 1'b1, "R6", "busy after strobe", {31'd0, stream_busy}, 32'd1);
            recv_word(VEC[i], "R4");
            check(stream_busy == 1'b1, "R6", "busy in last stop bit", {31'd0, stream_busy}, 32'd1);
            repeat (CPB) @(negedge clk);
            check(stream_busy == 1'b0, "R6", "busy cleared", {31'd0, stream_busy}, 32'd0);
            check(tx_line == 1'b1 && !drop_pulse, "R1", "idle between bursts",
                  {30'd0, tx_line, drop_pulse}, 32'd2);
        end

        // R3: start bit alone, then start merged with zero data bits
        send_word(32'hFFFF_FFFF);
        low_run(len);
        check(len == CPB, "R3", "start bit length", len, CPB);
        wait_idle();
        send_word(32'h0000_0000);
        low_run(len);
        check(len == 9*CPB, "R3", "start plus zero data length", len, 9*CPB);
        wait_idle();

        // R5: in_word changes during the burst
        fork
            recv_word(32'h1122_3344, "R5");
            begin
                repeat (3) @(negedge clk);
                in_word = 32'hDEAD_BEEF;
            end
            send_word(32'h1122_3344);
        join
        wait_idle();

        // R7: strobe during a burst is dropped
        send_word(32'hA5A5_5A5A);
        fork
            recv_word(32'hA5A5_5A5A, "R7");
            begin
                repeat (20) @(negedge clk);
                in_word  = 32'h0F0F_0F0F;
                in_valid = 1'b1;
                @(negedge clk);
                in_valid = 1'b0;
                check(drop_pulse == 1'b1, "R7", "drop pulse", {31'd0, drop_pulse}, 32'd1);
                @(negedge clk);
                check(drop_pulse == 1'b0, "R7", "drop pulse width", {31'd0, drop_pulse}, 32'd0);
            end
        join
        wait_idle();
        ok_all = 1'b1;
        for (int c = 0; c < 12*CPB*4; c++) begin
            @(negedge clk);
            if (tx_line !== 1'b1 || stream_busy !== 1'b0) ok_all = 1'b0;
        end
        check(ok_all, "R7", "dropped word not sent", {31'd0, ok_all}, 32'd1);

        // R8: accepted again after the drop
        send_word(32'hC001_D00D);
        recv_word(32'hC001_D00D, "R8");
        wait_idle();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule